// File: doc/BRIEF.md
# Pin-Change Interrupt Unit

This block watches a port of input pins, sampled once on the rising clock edge, and records edge events in sticky per-pin flags. Each pin has its own enable bit, a two-bit detection mode (any change, rising only, falling only) and an optional glitch filter. The filter acts only on the event path.

The flags are split into groups of eight pins. Each group's enabled flags are ORed onto one interrupt output. Software configures the unit and reads the flags through a small register port with a single-cycle write strobe and a combinational read. Flags are cleared by writing ones. The sampled, unfiltered pin levels can be read back through the same port.

Register addresses: 0 enable, 1 mode bit 0, 2 mode bit 1, 3 filter enable, 4 flags (write 1 to clear), 5 pin level (read only). Unused addresses read as zero.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, all configuration registers, the flags and every interrupt output are zero.
- R2: With mode pair {mode1,mode0} = 00 or 11, both a rising and a falling sampled level change set the pin's flag.
- R3: With mode pair 01, a rising change sets the flag and a falling change does not.
- R4: With mode pair 10, a falling change sets the flag and a rising change does not.
- R5: A pin whose enable bit (address 0) is clear never sets its flag.
- R6: A flag stays set until a 1 is written to its bit at address 4. Writing 0 leaves it unchanged. An event in the same cycle as a clear keeps the flag set.
- R7: Interrupt output g is the OR of flag AND enable over pins 8g to 8g+7. Clearing an enable bit hides that pin's flag from the output but leaves the flag readable.
- R8: With the filter bit set (address 3), a one-cycle sampled pulse sets no flag, and a pulse of two or more cycles does. An unfiltered change shows in the flag two clock edges after the pin changes. A filtered change shows two edges later, at four.
- R9: Address 5 returns the pin levels one clock edge after they change, without filtering.
- R10: While clk_en is low, no flag is set. Enabling it again raises no event for changes that happened while it was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Module enable; no events are detected while low |
| pins_in | input | 32 | Port pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| irq | output | 4 | One interrupt request per group of eight pins |

## Verification
A wrong previous-level or filter stage shows up as a missing or extra flag. It appears at address 4 and on the group's interrupt line exactly two edges after an unfiltered change, or four after a filtered one. The bench therefore samples at those edges and one edge earlier. A clear-mask or enable error shows at once: a flag that survives or vanishes on the write edge, or an interrupt line that disagrees with the flags it covers. Each mode encoding is driven through both edge directions, so a swapped mode decode fails within one vector.

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int NPINS = 32,
  parameter int GRP   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic [NPINS-1:0] pins_in,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [NPINS-1:0] wr_data,
  input  logic [2:0]       rd_addr,
  output logic [NPINS-1:0] rd_data,
  output logic [NPINS/GRP-1:0] irq
);
  localparam int NGRP = NPINS / GRP;
  localparam logic [2:0] A_EN = 3'd0, A_M0 = 3'd1, A_M1 = 3'd2,
                         A_GF = 3'd3, A_FLAG = 3'd4, A_PIN = 3'd5;

  logic [NPINS-1:0] en_q, m0_q, m1_q, gf_q, flags_q;
  logic [NPINS-1:0] samp_q, s1_q, fo_q, prev_q;
  logic [NPINS-1:0] level, rise, fall, sel_r, sel_f, sel_a, ev, clr;

  assign level = (gf_q & fo_q) | (~gf_q & samp_q);
  assign rise  = level & ~prev_q;
  assign fall  = ~level & prev_q;
  assign sel_r = ~m1_q & m0_q;
  assign sel_f = m1_q & ~m0_q;
  assign sel_a = ~(sel_r | sel_f);
  assign ev    = ((rise & (sel_r | sel_a)) | (fall & (sel_f | sel_a)))
                 & en_q & {NPINS{clk_en}};
  assign clr   = (wr_en && wr_addr == A_FLAG) ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0; m0_q <= '0; m1_q <= '0; gf_q <= '0; flags_q <= '0;
      samp_q <= '0; s1_q <= '0; fo_q <= '0; prev_q <= '0;
    end else begin
      samp_q  <= pins_in;
      s1_q    <= samp_q;
      fo_q    <= (~(samp_q ^ s1_q) & s1_q) | ((samp_q ^ s1_q) & fo_q);
      prev_q  <= level;
      flags_q <= (flags_q & ~clr) | ev;
      if (wr_en) begin
        case (wr_addr)
          A_EN:    en_q <= wr_data;
          A_M0:    m0_q <= wr_data;
          A_M1:    m1_q <= wr_data;
          A_GF:    gf_q <= wr_data;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_addr)
      A_EN:    rd_data = en_q;
      A_M0:    rd_data = m0_q;
      A_M1:    rd_data = m1_q;
      A_GF:    rd_data = gf_q;
      A_FLAG:  rd_data = flags_q;
      A_PIN:   rd_data = samp_q;
      default: rd_data = '0;
    endcase
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_irq
    assign irq[g] = |(flags_q[g*GRP +: GRP] & en_q[g*GRP +: GRP]);
  end

  // R10: no flag bit rises while the module enable is low
  a_r10_no_event_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ((flags_q & ~$past(flags_q)) == '0));

  // R5: a disabled pin never sets its flag
  a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q != '1) |=> ((flags_q & ~$past(flags_q) & ~$past(en_q)) == '0));

  // R6: a set flag only drops where a clear bit was written
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q != '0) |=> (($past(flags_q) & ~$past(clr) & ~flags_q) == '0));

  // R7: no flags means no interrupt request
  a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q == '0) |-> (irq == '0));
endmodule

// File: tb/gpio_edge_irq_bench.sv
module gpio_edge_irq_bench;
  localparam int PERIOD = 10;
  localparam logic [2:0] A_EN = 3'd0, A_M0 = 3'd1, A_M1 = 3'd2,
                         A_GF = 3'd3, A_FLAG = 3'd4, A_PIN = 3'd5;
  // {mode1, mode0, start level, end level, expected flag}
  localparam logic [4:0] VEC [0:7] = '{
    5'b00_01_1, 5'b00_10_1, 5'b01_01_1, 5'b01_10_0,
    5'b10_01_0, 5'b10_10_1, 5'b11_10_1, 5'b11_01_1 };

  logic clk = 0, rst_n = 0, clk_en = 1, wr_en = 0;
  logic [31:0] pins_in = '0, wr_data = '0, rd_data, v;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [3:0] irq;
  int checks = 0, fails = 0;
  bit done = 0;

  gpio_edge_irq u_gpio_edge_irq (.clk(clk), .rst_n(rst_n), .clk_en(clk_en),
    .pins_in(pins_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst_n = 1;
    wait_n(1);
    rd(A_FLAG, v); chk("R1 flags", v, 0);
    rd(A_EN, v);   chk("R1 enable", v, 0);
    chk("R1 irq", {28'b0, irq}, 0);

    wr(A_EN, '1);
    for (int i = 0; i < 8; i++) begin
      wr(A_M0, {31'b0, VEC[i][3]});
      wr(A_M1, {31'b0, VEC[i][4]});
      pins_in[0] = VEC[i][2];
      wait_n(4);
      wr(A_FLAG, '1);
      pins_in[0] = VEC[i][1];
      wait_n(2);
      rd(A_FLAG, v);
      chk($sformatf("R2/R3/R4 mode vector %0d", i), {31'b0, v[0]}, {31'b0, VEC[i][0]});
    end
    wr(A_M0, '0); wr(A_M1, '0);
    wait_n(3);
    wr(A_FLAG, '1);

    pins_in[1] = 1; wait_n(2);
    rd(A_FLAG, v); chk("R6 flag set", v, 32'h2);
    wr(A_FLAG, 0);
    rd(A_FLAG, v); chk("R6 write 0 keeps flag", v, 32'h2);
    wr(A_FLAG, 32'h2);
    rd(A_FLAG, v); chk("R6 write 1 clears", v, 0);
    pins_in[1] = 0; wait_n(1);
    wr(A_FLAG, 32'h2);
    rd(A_FLAG, v); chk("R6 set wins over clear", v, 32'h2);
    wr(A_FLAG, '1);

    pins_in[9] = 1; wait_n(2);
    chk("R7 group 1 irq", {28'b0, irq}, 32'h2);
    wr(A_EN, ~32'h200);
    chk("R7 masked irq", {28'b0, irq}, 0);
    rd(A_FLAG, v); chk("R7 flag still readable", v, 32'h200);
    wr(A_FLAG, '1);
    pins_in[9] = 0; wait_n(4);
    rd(A_FLAG, v); chk("R5 disabled pin quiet", v, 0);
    wr(A_EN, '1);

    wr(A_GF, 32'h3_0000);
    wait_n(2);
    pins_in[16] = 1; wait_n(1); pins_in[16] = 0; wait_n(6);
    rd(A_FLAG, v); chk("R8 one-cycle pulse rejected", v, 0);
    pins_in[16] = 1; wait_n(2); pins_in[16] = 0; wait_n(6);
    rd(A_FLAG, v); chk("R8 two-cycle pulse accepted", v, 32'h1_0000);
    wr(A_FLAG, '1);
    pins_in[17] = 1;
    rd(A_PIN, v); chk("R9 level before edge", v & 32'h2_0000, 0);
    wait_n(1);
    rd(A_PIN, v); chk("R9 unfiltered level after one edge", v & 32'h2_0000, 32'h2_0000);
    wait_n(2);
    rd(A_FLAG, v); chk("R8 filtered flag not yet at edge 3", v, 0);
    wait_n(1);
    rd(A_FLAG, v); chk("R8 filtered flag at edge 4", v, 32'h2_0000);
    wr(A_FLAG, '1);

    clk_en = 0;
    pins_in[2] = 1; wait_n(4);
    rd(A_FLAG, v); chk("R10 gated no flag", v, 0);
    clk_en = 1; wait_n(3);
    rd(A_FLAG, v); chk("R10 no event on re-enable", v, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule